// File: doc/BRIEF.md
# Debug Power and Reset Control Registers

This block provides the two small registers through which an external debugger powers up a core complex, holds it in reset and opens access to the rest of the debug register space. A control register requests wakeup of the core, memory and debug domains, asserts core and debug resets, and carries a debug-use bit. A status register shows which domains report power-good, whether the core still waits for power, and two sticky flags that record a reset of the core or of the debug logic.

The debugger reaches both registers through a plain single-cycle register port. Each register answers at a short local address and at a mirror address in the wider debug map. Access to the remaining debug registers is granted by `dbg_access_en`. It is raised only by a write that moves the debug-use bit from 0 to 1 while the debug logic is out of reset and powered. Software keeps access by writing the bit as 1 on every later control write.

Top module: `dbg_pwr_regs`

## Requirements
- R1: The control register resets to 0x00. Bits 0, 1, 2, 4, 6 and 7 are writable and hold core wakeup, memory wakeup, debug wakeup, core reset, debug reset and debug-use. Bits 3 and 5 always read 0.
- R2: `wake_core`, `wake_mem`, `wake_dbg`, `core_rst` and `dbg_rst` equal control bits 0, 1, 2, 4 and 6 from the clock edge that stores the write.
- R3: The control register answers at addresses 0x00 and 0x58 and the status register at 0x01 and 0x59. Reads of any other address return 0x00, and writes to them change nothing.
- R4: Status bits 0, 1 and 2 (core, memory and debug domain on) follow `pg_core`, `pg_mem` and `pg_dbg` after PG_STAGES clock edges.
- R5: Status bit 3 (core still needed) is 1 exactly while control bit 0 is set and status bit 0 is clear.
- R6: `dbg_access_en` rises only on a control write that takes bit 7 from 0 to 1 with bit 6 clear while status bit 2 is set. A later write of bit 7 as 1 keeps access. A write with bit 7 clear revokes it. A write of 1 over a stored 1 never grants access.
- R7: A control write with bit 6 set stores bit 7 as 0 and drops `dbg_access_en`.
- R8: Status bit 4 (core was reset) and bit 6 (debug was reset) set on the clock edge after control bit 4, or bit 6, is seen at 1. Both stay set through reads without the clear qualifier.
- R9: A status read with `reg_rd_clr` high returns the flags as they were and clears them at that clock edge. The qualifier has no effect on a control-register read.
- R10: When a clearing read meets a reset bit that is still asserted, the matching flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| reg_rd_clr | input | 1 | Clear qualifier for a status read |
| reg_rdata | output | 8 | Read data, 0 when no read strobe |
| wake_core | output | 1 | Core domain wakeup request |
| wake_mem | output | 1 | Memory domain wakeup request |
| wake_dbg | output | 1 | Debug domain wakeup request |
| core_rst | output | 1 | Core reset request |
| dbg_rst | output | 1 | Debug logic reset request |
| pg_core | input | 1 | Core domain power-good |
| pg_mem | input | 1 | Memory domain power-good |
| pg_dbg | input | 1 | Debug domain power-good |
| dbg_access_en | output | 1 | Debug register space access enable |

## Verification
Two events can meet in one cycle: a clearing status read, and the set condition of a sticky reset flag. The bench sets the core reset bit, then the debug reset bit, and keeps each one asserted while it issues a read with the clear qualifier. It then checks that the read returns the flag, that the next plain read still shows it, and that the other flag, whose reset bit has been released, is cleared. The grant logic has a similar meeting point: a debug-use rising edge in the same write as a debug reset must grant nothing. The full control-value sweep covers this case.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;
  // Control register field positions
  localparam int CB_WAKE_CORE = 0;
  localparam int CB_WAKE_MEM  = 1;
  localparam int CB_WAKE_DBG  = 2;
  localparam int CB_CORE_RST  = 4;
  localparam int CB_DBG_RST   = 6;
  localparam int CB_USE       = 7;

  // Status register field positions
  localparam int SB_CORE_ON   = 0;
  localparam int SB_MEM_ON    = 1;
  localparam int SB_DBG_ON    = 2;
  localparam int SB_CORE_NEED = 3;
  localparam int SB_CORE_WR   = 4;
  localparam int SB_DBG_WR    = 6;

  localparam int REG_W   = 8;
  localparam int NUM_DOM = 3;

  localparam logic [REG_W-1:0] CTRL_WR_MASK =
    (8'h1 << CB_WAKE_CORE) | (8'h1 << CB_WAKE_MEM) | (8'h1 << CB_WAKE_DBG) |
    (8'h1 << CB_CORE_RST)  | (8'h1 << CB_DBG_RST)  | (8'h1 << CB_USE);

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT} reg_sel_e;
endpackage

// File: rtl/dbg_pwr_rst_sync.sv
module dbg_pwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dbg_pwr_ctrl.sv
module dbg_pwr_ctrl
  import dbg_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             dbg_on,
  output logic [REG_W-1:0] ctrl_q,
  output logic             access_en
);
  logic [REG_W-1:0] ctrl_d;
  logic             acc_q, acc_d;

  always_comb begin
    ctrl_d = wdata & CTRL_WR_MASK;
    if (ctrl_d[CB_DBG_RST]) ctrl_d[CB_USE] = 1'b0;
    // keep when already granted, grant only on a 0->1 step of the use bit
    acc_d = ctrl_d[CB_USE] & (acc_q | (~ctrl_q[CB_USE] & dbg_on));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      acc_q  <= 1'b0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      acc_q  <= acc_d;
    end
  end

  assign access_en = acc_q;
endmodule

// File: rtl/dbg_pwr_stat.sv
module dbg_pwr_stat
  import dbg_pwr_pkg::*;
#(
  parameter int PG_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DOM-1:0] pg,
  input  logic               wake_core,
  input  logic               core_rst_req,
  input  logic               dbg_rst_req,
  input  logic               clr_en,
  output logic [REG_W-1:0]   stat_q
);
  logic [NUM_DOM-1:0] dom_on;
  logic core_wr_q, core_wr_d, dbg_wr_q, dbg_wr_d;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [PG_STAGES-1:0] pipe_q;
    logic [PG_STAGES-1:0] pipe_d;
    if (PG_STAGES == 1) begin : g_one
      assign pipe_d = pg[d];
    end else begin : g_many
      assign pipe_d = {pipe_q[PG_STAGES-2:0], pg[d]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end
    assign dom_on[d] = pipe_q[PG_STAGES-1];
  end

  always_comb begin
    core_wr_d = (core_wr_q & ~clr_en) | core_rst_req;
    dbg_wr_d  = (dbg_wr_q  & ~clr_en) | dbg_rst_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_wr_q <= 1'b0;
      dbg_wr_q  <= 1'b0;
    end else begin
      core_wr_q <= core_wr_d;
      dbg_wr_q  <= dbg_wr_d;
    end
  end

  always_comb begin
    stat_q               = '0;
    stat_q[SB_CORE_ON]   = dom_on[0];
    stat_q[SB_MEM_ON]    = dom_on[1];
    stat_q[SB_DBG_ON]    = dom_on[2];
    stat_q[SB_CORE_NEED] = wake_core & ~dom_on[0];
    stat_q[SB_CORE_WR]   = core_wr_q;
    stat_q[SB_DBG_WR]    = dbg_wr_q;
  end
endmodule

// File: rtl/dbg_pwr_regs.sv
module dbg_pwr_regs
  import dbg_pwr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_LOCAL = 'h00,
  parameter logic [ADDR_W-1:0] STAT_LOCAL = 'h01,
  parameter logic [ADDR_W-1:0] CTRL_MAP   = 'h58,
  parameter logic [ADDR_W-1:0] STAT_MAP   = 'h59,
  parameter int PG_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_rd_clr,
  output logic [7:0]        reg_rdata,
  output logic              wake_core,
  output logic              wake_mem,
  output logic              wake_dbg,
  output logic              core_rst,
  output logic              dbg_rst,
  input  logic              pg_core,
  input  logic              pg_mem,
  input  logic              pg_dbg,
  output logic              dbg_access_en
);
  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             stat_sel;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] stat_q;

  dbg_pwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr == CTRL_LOCAL || reg_addr == CTRL_MAP)      sel = SEL_CTRL;
    else if (reg_addr == STAT_LOCAL || reg_addr == STAT_MAP) sel = SEL_STAT;
  end

  assign stat_sel = (sel == SEL_STAT);

  dbg_pwr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr && sel == SEL_CTRL),
    .wdata     (reg_wdata),
    .dbg_on    (stat_q[SB_DBG_ON]),
    .ctrl_q    (ctrl_q),
    .access_en (dbg_access_en)
  );

  dbg_pwr_stat #(.PG_STAGES(PG_STAGES)) u_stat (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pg           ({pg_dbg, pg_mem, pg_core}),
    .wake_core    (ctrl_q[CB_WAKE_CORE]),
    .core_rst_req (ctrl_q[CB_CORE_RST]),
    .dbg_rst_req  (ctrl_q[CB_DBG_RST]),
    .clr_en       (reg_rd && reg_rd_clr && stat_sel),
    .stat_q       (stat_q)
  );

  assign wake_core = ctrl_q[CB_WAKE_CORE];
  assign wake_mem  = ctrl_q[CB_WAKE_MEM];
  assign wake_dbg  = ctrl_q[CB_WAKE_DBG];
  assign core_rst  = ctrl_q[CB_CORE_RST];
  assign dbg_rst   = ctrl_q[CB_DBG_RST];

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_CTRL: reg_rdata = ctrl_q;
        SEL_STAT: reg_rdata = stat_q;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_pwr_regs_chk.sv
module dbg_pwr_regs_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_rd_clr,
  input logic [7:0] reg_wdata,
  input logic       stat_sel,
  input logic [7:0] stat_q,
  input logic       wake_core,
  input logic       core_rst,
  input logic       dbg_rst,
  input logic       dbg_access_en
);
  a_r7_reset_blocks_access: assert property (@(posedge clk) disable iff (!rst_ok)
    dbg_rst |-> !dbg_access_en);

  a_r6_grant_needs_use_write: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(dbg_access_en) |-> ($past(reg_wr) && $past(reg_wdata[7]) && !$past(reg_wdata[6])));

  a_r6_revoke_needs_write: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(dbg_access_en) |-> $past(reg_wr));

  a_r9_core_flag_clear_by_read: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(stat_q[4]) |-> ($past(reg_rd) && $past(reg_rd_clr) && $past(stat_sel)));

  a_r9_dbg_flag_clear_by_read: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(stat_q[6]) |-> ($past(reg_rd) && $past(reg_rd_clr) && $past(stat_sel)));

  a_r10_core_set_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    core_rst |=> stat_q[4]);

  a_r10_dbg_set_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    dbg_rst |=> stat_q[6]);

  a_r5_need_implies_wake: assert property (@(posedge clk) disable iff (!rst_ok)
    stat_q[3] |-> wake_core);
endmodule

bind dbg_pwr_regs dbg_pwr_regs_chk u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_rd_clr    (reg_rd_clr),
  .reg_wdata     (reg_wdata),
  .stat_sel      (stat_sel),
  .stat_q        (stat_q),
  .wake_core     (wake_core),
  .core_rst      (core_rst),
  .dbg_rst       (dbg_rst),
  .dbg_access_en (dbg_access_en)
);

// File: tb/tb_dbg_pwr_regs.sv
module tb_dbg_pwr_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr, reg_rd, reg_rd_clr;
  logic [7:0] reg_rdata;
  logic       wake_core, wake_mem, wake_dbg, core_rst, dbg_rst;
  logic       pg_core, pg_mem, pg_dbg;
  logic       dbg_access_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbg_pwr_regs #(.ADDR_W(7), .PG_STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rd_clr(reg_rd_clr), .reg_rdata(reg_rdata),
    .wake_core(wake_core), .wake_mem(wake_mem), .wake_dbg(wake_dbg),
    .core_rst(core_rst), .dbg_rst(dbg_rst),
    .pg_core(pg_core), .pg_mem(pg_mem), .pg_dbg(pg_dbg),
    .dbg_access_en(dbg_access_en)
  );

  function automatic logic [7:0] outs();
    return {2'b00, dbg_access_en, dbg_rst, core_rst, wake_dbg, wake_mem, wake_core};
  endfunction

  function automatic logic [7:0] exp_outs(input logic [7:0] v, input logic acc);
    return {2'b00, acc, v[6], v[4], v[2], v[1], v[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic c, output logic [7:0] q);
    reg_addr = a; reg_rd = 1'b1; reg_rd_clr = c;
    #1 q = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0; reg_rd_clr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] ev;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_rd_clr = 1'b0;
    pg_core = 1'b0; pg_mem = 1'b0; pg_dbg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R1 reset outputs", outs(), 8'h00);
    rd(7'h00, 1'b0, q); chk("R1 reset control", q, 8'h00);
    rd(7'h01, 1'b0, q); chk("R1 reset status", q, 8'h00);

    // core wakeup with core still powering up
    wr(7'h00, 8'h01);
    rd(7'h01, 1'b0, q); chk("R5 still needed while unpowered", q, 8'h08);
    pg_core = 1'b1; idle();
    rd(7'h01, 1'b0, q); chk("R4 core on after power-good", q, 8'h01);
    pg_mem = 1'b1; pg_dbg = 1'b1; idle();
    rd(7'h01, 1'b0, q); chk("R4 all domains on", q, 8'h07);
    pg_core = 1'b0; idle();
    rd(7'h01, 1'b0, q); chk("R5 still needed after core loses power", q, 8'h0E);
    pg_core = 1'b1; idle();

    // access grant needs the debug domain on
    pg_dbg = 1'b0; idle();
    wr(7'h00, 8'h00);
    wr(7'h00, 8'h80);
    chk("R6 no grant with debug domain off", outs(), exp_outs(8'h80, 1'b0));
    pg_dbg = 1'b1; idle();
    wr(7'h00, 8'h80);
    chk("R6 rewrite of 1 does not grant", outs(), exp_outs(8'h80, 1'b0));
    wr(7'h00, 8'h00);
    wr(7'h00, 8'h80);
    chk("R6 grant on 0 to 1", outs(), exp_outs(8'h80, 1'b1));
    wr(7'h00, 8'h81);
    chk("R6 rewrite of 1 keeps access", outs(), exp_outs(8'h81, 1'b1));
    wr(7'h00, 8'h01);
    chk("R6 clear revokes access", outs(), exp_outs(8'h01, 1'b0));
    wr(7'h00, 8'h80);
    chk("R6 regrant", outs(), exp_outs(8'h80, 1'b1));
    wr(7'h00, 8'hC0);
    chk("R7 debug reset revokes access", outs(), exp_outs(8'h40, 1'b0));
    rd(7'h00, 1'b0, q); chk("R7 use bit stored as 0", q, 8'h40);
    wr(7'h00, 8'h80);
    chk("R7 fresh edge after reset grants", outs(), exp_outs(8'h80, 1'b1));

    // full sweep of control values, alternating the two control addresses
    for (int v = 0; v < 256; v++) begin
      logic [6:0] a;
      a = v[0] ? 7'h58 : 7'h00;
      wr(a, 8'h00);
      wr(a, v[7:0]);
      ev = v[7:0] & 8'hD7;
      if (ev[6]) ev[7] = 1'b0;
      rd(v[1] ? 7'h58 : 7'h00, 1'b0, q);
      chk("R1 sweep readback", q, ev);
      chk("R2 sweep outputs", outs(), exp_outs(ev, v[7] & ~v[6]));
    end

    // address decode and mirrors
    wr(7'h00, 8'h85);
    wr(7'h02, 8'h00);
    rd(7'h00, 1'b0, q); chk("R3 unmapped write ignored", q, 8'h85);
    chk("R3 unmapped write keeps outputs", outs(), exp_outs(8'h85, 1'b1));
    rd(7'h02, 1'b0, q); chk("R3 unmapped read is zero", q, 8'h00);
    rd(7'h5A, 1'b0, q); chk("R3 unmapped high read is zero", q, 8'h00);
    rd(7'h58, 1'b0, q); chk("R3 control mirror read", q, 8'h85);
    wr(7'h58, 8'h81);
    rd(7'h00, 1'b0, q); chk("R3 control mirror write", q, 8'h81);

    // sticky flags: clean start with domains off
    pg_core = 1'b0; pg_mem = 1'b0; pg_dbg = 1'b0;
    wr(7'h00, 8'h00); idle();
    rd(7'h01, 1'b1, q);
    rd(7'h59, 1'b0, q); chk("R9 flags cleared before sticky test", q, 8'h00);

    wr(7'h00, 8'h10); idle();
    wr(7'h00, 8'h00);
    rd(7'h01, 1'b0, q); chk("R8 core flag set", q, 8'h10);
    rd(7'h59, 1'b0, q); chk("R8 core flag held, status mirror", q, 8'h10);
    rd(7'h00, 1'b1, q); chk("R9 clear qualifier on control read", q, 8'h00);
    rd(7'h01, 1'b0, q); chk("R9 control read did not clear", q, 8'h10);
    rd(7'h59, 1'b1, q); chk("R9 clearing read returns flag", q, 8'h10);
    rd(7'h01, 1'b0, q); chk("R9 flag cleared", q, 8'h00);

    // clear meets active reset
    wr(7'h00, 8'h10); idle();
    rd(7'h01, 1'b1, q); chk("R10 clearing read with core reset held", q, 8'h10);
    rd(7'h01, 1'b0, q); chk("R10 core flag survives clear", q, 8'h10);
    wr(7'h00, 8'h40); idle();
    rd(7'h01, 1'b0, q); chk("R8 debug flag set", q, 8'h50);
    rd(7'h01, 1'b1, q); chk("R10 clearing read with debug reset held", q, 8'h50);
    rd(7'h01, 1'b0, q); chk("R10 debug flag survives, core flag cleared", q, 8'h40);
    wr(7'h00, 8'h00);
    rd(7'h01, 1'b1, q); chk("R9 debug flag returned", q, 8'h40);
    rd(7'h01, 1'b0, q); chk("R9 debug flag cleared", q, 8'h00);

    summary();
    $finish;
  end
endmodule